// File: doc/BRIEF.md
# Video Pattern and Nametable Mapper

This block turns a 14-bit address from the video side into a physical location in one of three memories: pattern ROM, pattern RAM, or a 4 KB nametable RAM. The video space is split into twelve 1 KB slots. Eight slots cover the pattern area and four cover the nametables. Each slot holds a kind tag and a bank number. The physical address is that bank number placed above the ten offset bits of the incoming address.

Software-side logic reprograms the slots with one-cycle configuration commands. A command can bank pattern ROM at 1, 2, 4 or 8 KB granularity, place a 1 KB page of pattern RAM, apply one of five nametable mirroring presets, or give the four nametable slots any page values. The block keeps one sticky flag per 4 KB group of pattern RAM and sets the flag when any page of that group is mapped.

The lookup is purely combinational and accepts an address in every cycle, so the lookup path has no valid/ready pair and never applies back-pressure. Configuration is a plain strobe that is always accepted.

Top module: `vmap_top`

## Requirements
- R1: After reset, pattern slot s (0..7) maps to pattern ROM bank s and nametable slot 8+j maps to nametable page j. All pattern-RAM group flags read 0.
- R2: Address bits [13:10] select the slot. When bit 13 is 1, bit 12 is ignored and bits [11:10] pick nametable slot 8..11, so 0x3000–0x3EFF folds onto 0x2000–0x2EFF. `map_phys` = {slot bank, `va_addr[9:0]`}. `map_kind` encodes 0 = pattern ROM, 1 = pattern RAM, 2 = nametable RAM.
- R3: Op 0 (ROM 1 KB) loads slot `cfg_slot` with `cfg_bank` modulo ROM_BANKS.
- R4: Ops 1 and 2 (ROM 2 KB and 4 KB, n = 2 or 4) load slot (`cfg_slot`+k) mod 8 with (`cfg_bank`·n+k) mod ROM_BANKS for k = 0..n-1. All other pattern slots are left as they were.
- R5: Op 3 (ROM 8 KB) loads every pattern slot i with (`cfg_bank`·8+i) mod ROM_BANKS and ignores `cfg_slot`.
- R6: Op 4 (pattern RAM 1 KB) loads slot `cfg_slot` with kind pattern RAM and bank `cfg_bank[4:0]`. Higher bank bits are discarded.
- R7: Op 4 sets bit `cfg_bank[4:2]` of `ram_used`. Bits only clear on reset.
- R8: Op 5 applies a mirroring preset, given as `cfg_mirror` followed by pages for slots 8..11:
  - 0 gives 0,0,1,1
  - 1 gives 0,1,0,1
  - 2 gives 0,0,0,0
  - 3 gives 1,1,1,1
  - 4 gives 0,1,2,3
  - codes 5..7 leave the nametable slots unchanged.
- R9: Op 6 loads nametable slot 8+j with `cfg_nt[2j+1:2j]`.
- R10: `map_we` is high only when `va_we` is high and the addressed slot is not pattern ROM. Writes to ROM slots are dropped.
- R11: A command takes effect at the rising edge where `cfg_en` is high. A lookup in that same cycle still returns the previous mapping. Op 7 and `cfg_en` low change nothing, and pattern ops never touch the nametable slots (and the reverse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Command strobe |
| cfg_op | input | 3 | Command code (0..7) |
| cfg_slot | input | 3 | First pattern slot for ops 0,1,2,4 |
| cfg_bank | input | CFG_BW | Bank number for ops 0..4 |
| cfg_mirror | input | 3 | Mirroring preset code for op 5 |
| cfg_nt | input | 8 | Four 2-bit nametable pages for op 6 |
| va_addr | input | 14 | Video-side address |
| va_we | input | 1 | Video-side write request |
| map_kind | output | 2 | Memory selected by the addressed slot |
| map_phys | output | SB_W+10 | Physical address within that memory |
| map_we | output | 1 | Write permitted to the selected memory |
| ram_used | output | 8 | Sticky flags per 4 KB pattern-RAM group |

## Verification
A lookup and a configuration command can fall in the same cycle and target the same slot. The bench holds an address on a pattern slot while it strobes a ROM reload of that slot. It samples before the edge and expects the old bank, then samples after the edge and expects the new one. Pattern-RAM mapping and flag setting also coincide: every RAM load is judged on both the slot contents and the flag vector in the following cycle.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
  localparam int N_PAT      = 8;
  localparam int N_NT       = 4;
  localparam int N_SLOT     = N_PAT + N_NT;
  localparam int OFS_W      = 10;
  localparam int PRAM_BW    = 5;
  localparam int NT_BW      = 2;
  localparam int N_GROUP    = 8;

  typedef enum logic [1:0] {
    KIND_PROM  = 2'd0,
    KIND_PRAM  = 2'd1,
    KIND_NTRAM = 2'd2
  } slot_kind_e;

  typedef enum logic [2:0] {
    OP_ROM1K  = 3'd0,
    OP_ROM2K  = 3'd1,
    OP_ROM4K  = 3'd2,
    OP_ROM8K  = 3'd3,
    OP_PRAM1K = 3'd4,
    OP_MIRROR = 3'd5,
    OP_NTSET  = 3'd6,
    OP_IDLE   = 3'd7
  } cfg_op_e;
endpackage

// File: rtl/vmap_cfg_decode.sv
module vmap_cfg_decode
  import vmap_pkg::*;
#(
  parameter int ROM_BANKS = 96,
  parameter int CFG_BW    = 8,
  parameter int SB_W      = 7
) (
  input  logic                          cfg_en,
  input  logic [2:0]                    cfg_op,
  input  logic [2:0]                    cfg_slot,
  input  logic [CFG_BW-1:0]             cfg_bank,
  input  logic [2:0]                    cfg_mirror,
  input  logic [2*N_NT-1:0]             cfg_nt,
  output logic [N_SLOT-1:0]             wr_mask,
  output logic [N_SLOT-1:0][1:0]        nxt_kind,
  output logic [N_SLOT-1:0][SB_W-1:0]   nxt_bank,
  output logic [N_GROUP-1:0]            used_set
);
  localparam int RAW_W = CFG_BW + 3;

  logic is_rom_op;
  assign is_rom_op = (cfg_op[2] == 1'b0);

  for (genvar s = 0; s < N_PAT; s++) begin : g_pat
    logic [2:0]       base;
    logic [2:0]       rel;
    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] wrapped;
    logic             in_span;
    always_comb begin
      base    = (cfg_op == OP_ROM8K) ? 3'd0 : cfg_slot;
      rel     = 3'(s) - base;
      in_span = ((rel >> cfg_op[1:0]) == 3'd0);
      raw     = (RAW_W'(cfg_bank) << cfg_op[1:0]) + RAW_W'(rel);
      wrapped = raw % RAW_W'(ROM_BANKS);
      wr_mask[s]  = 1'b0;
      nxt_kind[s] = KIND_PROM;
      nxt_bank[s] = '0;
      if (cfg_en && is_rom_op) begin
        wr_mask[s]  = in_span;
        nxt_bank[s] = wrapped[SB_W-1:0];
      end else if (cfg_en && cfg_op == OP_PRAM1K) begin
        wr_mask[s]  = (rel == 3'd0);
        nxt_kind[s] = KIND_PRAM;
        nxt_bank[s] = SB_W'(cfg_bank[PRAM_BW-1:0]);
      end
    end
  end

  for (genvar j = 0; j < N_NT; j++) begin : g_nt
    logic [NT_BW-1:0] preset;
    logic             preset_ok;
    always_comb begin
      preset_ok = 1'b1;
      case (cfg_mirror)
        3'd0:    preset = NT_BW'(j >> 1);
        3'd1:    preset = NT_BW'(j & 1);
        3'd2:    preset = 2'd0;
        3'd3:    preset = 2'd1;
        3'd4:    preset = NT_BW'(j);
        default: begin preset = 2'd0; preset_ok = 1'b0; end
      endcase
      wr_mask[N_PAT+j]  = 1'b0;
      nxt_kind[N_PAT+j] = KIND_NTRAM;
      nxt_bank[N_PAT+j] = '0;
      if (cfg_en && cfg_op == OP_MIRROR) begin
        wr_mask[N_PAT+j]  = preset_ok;
        nxt_bank[N_PAT+j] = SB_W'(preset);
      end else if (cfg_en && cfg_op == OP_NTSET) begin
        wr_mask[N_PAT+j]  = 1'b1;
        nxt_bank[N_PAT+j] = SB_W'(cfg_nt[NT_BW*j +: NT_BW]);
      end
    end
  end

  always_comb begin
    used_set = '0;
    if (cfg_en && cfg_op == OP_PRAM1K)
      used_set[cfg_bank[PRAM_BW-1:2]] = 1'b1;
  end
endmodule

// File: rtl/vmap_slot_file.sv
module vmap_slot_file
  import vmap_pkg::*;
#(
  parameter int SB_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SLOT-1:0]             wr_mask,
  input  logic [N_SLOT-1:0][1:0]        nxt_kind,
  input  logic [N_SLOT-1:0][SB_W-1:0]   nxt_bank,
  input  logic [N_GROUP-1:0]            used_set,
  output logic [N_SLOT-1:0][1:0]        slot_kind,
  output logic [N_SLOT-1:0][SB_W-1:0]   slot_bank,
  output logic [N_GROUP-1:0]            used_q
);
  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    localparam logic [1:0]      RST_KIND = (s < N_PAT) ? KIND_PROM : KIND_NTRAM;
    localparam logic [SB_W-1:0] RST_BANK = (s < N_PAT) ? SB_W'(s) : SB_W'(s - N_PAT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_kind[s] <= RST_KIND;
        slot_bank[s] <= RST_BANK;
      end else if (wr_mask[s]) begin
        slot_kind[s] <= nxt_kind[s];
        slot_bank[s] <= nxt_bank[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_q | used_set;
  end
endmodule

// File: rtl/vmap_lookup.sv
module vmap_lookup
  import vmap_pkg::*;
#(
  parameter int SB_W = 7
) (
  input  logic [N_SLOT-1:0][1:0]        slot_kind,
  input  logic [N_SLOT-1:0][SB_W-1:0]   slot_bank,
  input  logic [13:0]                   va_addr,
  input  logic                          va_we,
  output logic [1:0]                    map_kind,
  output logic [SB_W+OFS_W-1:0]         map_phys,
  output logic                          map_we
);
  logic [3:0] idx;
  always_comb begin
    idx      = va_addr[13] ? {2'b10, va_addr[11:10]} : {1'b0, va_addr[12:10]};
    map_kind = slot_kind[idx];
    map_phys = {slot_bank[idx], va_addr[OFS_W-1:0]};
    map_we   = va_we && (slot_kind[idx] != KIND_PROM);
  end
endmodule

// File: rtl/vmap_top.sv
module vmap_top
  import vmap_pkg::*;
#(
  parameter int ROM_BANKS = 96,
  parameter int CFG_BW    = 8,
  localparam int ROM_BW   = $clog2(ROM_BANKS),
  localparam int SB_W     = (ROM_BW > PRAM_BW) ? ROM_BW : PRAM_BW,
  localparam int PHYS_W   = SB_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [2:0]        cfg_op,
  input  logic [2:0]        cfg_slot,
  input  logic [CFG_BW-1:0] cfg_bank,
  input  logic [2:0]        cfg_mirror,
  input  logic [7:0]        cfg_nt,
  input  logic [13:0]       va_addr,
  input  logic              va_we,
  output logic [1:0]        map_kind,
  output logic [PHYS_W-1:0] map_phys,
  output logic              map_we,
  output logic [7:0]        ram_used
);
  logic [N_SLOT-1:0]            wr_mask;
  logic [N_SLOT-1:0][1:0]       nxt_kind;
  logic [N_SLOT-1:0][SB_W-1:0]  nxt_bank;
  logic [N_GROUP-1:0]           used_set;
  logic [N_SLOT-1:0][1:0]       slot_kind;
  logic [N_SLOT-1:0][SB_W-1:0]  slot_bank;

  vmap_cfg_decode #(.ROM_BANKS(ROM_BANKS), .CFG_BW(CFG_BW), .SB_W(SB_W)) u_dec (
    .cfg_en(cfg_en), .cfg_op(cfg_op), .cfg_slot(cfg_slot), .cfg_bank(cfg_bank),
    .cfg_mirror(cfg_mirror), .cfg_nt(cfg_nt),
    .wr_mask(wr_mask), .nxt_kind(nxt_kind), .nxt_bank(nxt_bank), .used_set(used_set)
  );

  vmap_slot_file #(.SB_W(SB_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .nxt_kind(nxt_kind),
    .nxt_bank(nxt_bank), .used_set(used_set),
    .slot_kind(slot_kind), .slot_bank(slot_bank), .used_q(ram_used)
  );

  vmap_lookup #(.SB_W(SB_W)) u_look (
    .slot_kind(slot_kind), .slot_bank(slot_bank), .va_addr(va_addr), .va_we(va_we),
    .map_kind(map_kind), .map_phys(map_phys), .map_we(map_we)
  );
endmodule

// File: rtl/vmap_chk.sv
module vmap_chk #(
  parameter int ROM_BANKS = 96,
  parameter int CFG_BW    = 8,
  parameter int PHYS_W    = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [2:0]        cfg_op,
  input logic [CFG_BW-1:0] cfg_bank,
  input logic [13:0]       va_addr,
  input logic              va_we,
  input logic [1:0]        map_kind,
  input logic [PHYS_W-1:0] map_phys,
  input logic              map_we,
  input logic [7:0]        ram_used
);
  localparam int BK_W = PHYS_W - 10;

  AST_NT_AREA_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    va_addr[13] |-> map_kind == 2'd2); // R2
  AST_ROM_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    map_kind == 2'd0 |-> map_phys[PHYS_W-1:10] < BK_W'(ROM_BANKS)); // R3
  AST_PRAM_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    map_kind == 2'd1 |-> map_phys[PHYS_W-1:15] == '0); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_op == 3'd4) |=> ram_used[$past(cfg_bank[4:2])]); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_used & $past(ram_used)) == $past(ram_used)); // R7
  AST_NO_ROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (map_kind == 2'd0 || !va_we) |-> !map_we); // R10
  AST_HOLD_WITHOUT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en ##1 $stable(va_addr) |-> $stable(map_phys) && $stable(map_kind)); // R11
endmodule

bind vmap_top vmap_chk #(.ROM_BANKS(ROM_BANKS), .CFG_BW(CFG_BW), .PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_op(cfg_op), .cfg_bank(cfg_bank),
  .va_addr(va_addr), .va_we(va_we), .map_kind(map_kind), .map_phys(map_phys),
  .map_we(map_we), .ram_used(ram_used)
);

// File: tb/test_vmap_top.sv
module test_vmap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [2:0]  cfg_op = 3'd7;
  logic [2:0]  cfg_slot = '0;
  logic [7:0]  cfg_bank = '0;
  logic [2:0]  cfg_mirror = '0;
  logic [7:0]  cfg_nt = '0;
  logic [13:0] va_addr = '0;
  logic        va_we = 1'b0;
  logic [1:0]  map_kind;
  logic [16:0] map_phys;
  logic        map_we;
  logic [7:0]  ram_used;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  vmap_top i_vmap_top (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_op(cfg_op), .cfg_slot(cfg_slot),
    .cfg_bank(cfg_bank), .cfg_mirror(cfg_mirror), .cfg_nt(cfg_nt),
    .va_addr(va_addr), .va_we(va_we), .map_kind(map_kind), .map_phys(map_phys),
    .map_we(map_we), .ram_used(ram_used)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        en;
    logic [2:0]  op;
    logic [2:0]  slot;
    logic [7:0]  bank;
    logic [2:0]  mir;
    logic [7:0]  nt;
    logic [13:0] addr;
    logic        we;
    logic [1:0]  kind;
    logic [6:0]  ebank;
    logic        ewe;
    logic [7:0]  used;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{8'd10, 1'b0, 3'd7, 3'd0, 8'd0,   3'd0, 8'h00, 14'h0C00, 1'b1, 2'd0, 7'd3,  1'b0, 8'h00}, // R10 R1
    '{8'd3,  1'b1, 3'd0, 3'd2, 8'd100, 3'd0, 8'h00, 14'h0955, 1'b0, 2'd0, 7'd4,  1'b0, 8'h00}, // R3 wrap
    '{8'd4,  1'b1, 3'd1, 3'd7, 8'd50,  3'd0, 8'h00, 14'h0003, 1'b0, 2'd0, 7'd5,  1'b0, 8'h00}, // R4 slot wrap
    '{8'd4,  1'b0, 3'd7, 3'd0, 8'd0,   3'd0, 8'h00, 14'h1C10, 1'b0, 2'd0, 7'd4,  1'b0, 8'h00}, // R4
    '{8'd4,  1'b1, 3'd2, 3'd5, 8'd30,  3'd0, 8'h00, 14'h0001, 1'b0, 2'd0, 7'd27, 1'b0, 8'h00}, // R4 4K
    '{8'd4,  1'b0, 3'd7, 3'd0, 8'd0,   3'd0, 8'h00, 14'h1000, 1'b1, 2'd0, 7'd4,  1'b0, 8'h00}, // R4 untouched
    '{8'd5,  1'b1, 3'd3, 3'd3, 8'd11,  3'd0, 8'h00, 14'h0A00, 1'b0, 2'd0, 7'd90, 1'b0, 8'h00}, // R5
    '{8'd5,  1'b0, 3'd7, 3'd0, 8'd0,   3'd0, 8'h00, 14'h1FFF, 1'b0, 2'd0, 7'd95, 1'b0, 8'h00}, // R5
    '{8'd6,  1'b1, 3'd4, 3'd1, 8'h2D,  3'd0, 8'h00, 14'h07FF, 1'b1, 2'd1, 7'd13, 1'b1, 8'h08}, // R6 R7
    '{8'd7,  1'b1, 3'd4, 3'd6, 8'hFF,  3'd0, 8'h00, 14'h1800, 1'b0, 2'd1, 7'd31, 1'b0, 8'h88}, // R6 R7
    '{8'd8,  1'b1, 3'd5, 3'd0, 8'd0,   3'd0, 8'h00, 14'h2400, 1'b0, 2'd2, 7'd0,  1'b0, 8'h88}, // R8 horiz
    '{8'd8,  1'b0, 3'd7, 3'd0, 8'd0,   3'd0, 8'h00, 14'h2800, 1'b0, 2'd2, 7'd1,  1'b0, 8'h88}, // R8
    '{8'd8,  1'b1, 3'd5, 3'd0, 8'd0,   3'd1, 8'h00, 14'h2C00, 1'b0, 2'd2, 7'd1,  1'b0, 8'h88}, // R8 vert
    '{8'd8,  1'b1, 3'd5, 3'd0, 8'd0,   3'd6, 8'h00, 14'h2800, 1'b0, 2'd2, 7'd0,  1'b0, 8'h88}, // R8 bad code
    '{8'd2,  1'b1, 3'd5, 3'd0, 8'd0,   3'd3, 8'h00, 14'h3000, 1'b0, 2'd2, 7'd1,  1'b0, 8'h88}, // R2 fold
    '{8'd8,  1'b1, 3'd5, 3'd0, 8'd0,   3'd4, 8'h00, 14'h3EFF, 1'b1, 2'd2, 7'd3,  1'b1, 8'h88}, // R8 four
    '{8'd8,  1'b1, 3'd5, 3'd0, 8'd0,   3'd2, 8'h00, 14'h2C00, 1'b0, 2'd2, 7'd0,  1'b0, 8'h88}, // R8 low
    '{8'd9,  1'b1, 3'd6, 3'd0, 8'd0,   3'd0, 8'h9C, 14'h2400, 1'b0, 2'd2, 7'd3,  1'b0, 8'h88}, // R9
    '{8'd9,  1'b0, 3'd7, 3'd0, 8'd0,   3'd0, 8'h00, 14'h3800, 1'b1, 2'd2, 7'd1,  1'b1, 8'h88}, // R9
    '{8'd11, 1'b0, 3'd7, 3'd0, 8'd0,   3'd0, 8'h00, 14'h0400, 1'b1, 2'd1, 7'd13, 1'b1, 8'h88}  // R11
  };

  task automatic check(input string req, input logic [1:0] ek, input logic [6:0] eb,
                       input logic ewe, input logic [7:0] eu);
    logic [16:0] ep;
    ep = {eb, va_addr[9:0]};
    n_chk++;
    if (map_kind !== ek || map_phys !== ep || map_we !== ewe || ram_used !== eu) begin
      n_bad++;
      $display("FAIL %s addr=%h kind=%0d/%0d phys=%h/%h we=%b/%b used=%h/%h", req, va_addr,
               map_kind, ek, map_phys, ep, map_we, ewe, ram_used, eu);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400us;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset mapping of every slot
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      va_addr = (s < 8) ? 14'(s * 1024) : 14'(14'h2000 + (s - 8) * 1024);
      #1ns;
      if (s < 8) check("R1", 2'd0, 7'(s), 1'b0, 8'h00);
      else       check("R1", 2'd2, 7'(s - 8), 1'b0, 8'h00);
    end
    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfg_en = VEC[v].en; cfg_op = VEC[v].op; cfg_slot = VEC[v].slot;
      cfg_bank = VEC[v].bank; cfg_mirror = VEC[v].mir; cfg_nt = VEC[v].nt;
      va_addr = VEC[v].addr; va_we = VEC[v].we;
      @(posedge clk);
      #1ns;
      check($sformatf("R%0d vec%0d", VEC[v].req, v), VEC[v].kind, VEC[v].ebank,
            VEC[v].ewe, VEC[v].used);
    end
    // R11: lookup and reload of the same slot in one cycle
    @(negedge clk);
    cfg_en = 1'b1; cfg_op = 3'd0; cfg_slot = 3'd2; cfg_bank = 8'd77;
    va_addr = 14'h0812; va_we = 1'b0;
    #1ns;
    check("R11 before edge", 2'd0, 7'd90, 1'b0, 8'h88);
    @(posedge clk);
    #1ns;
    check("R11 after edge", 2'd0, 7'd77, 1'b0, 8'h88);
    @(negedge clk);
    cfg_en = 1'b0; cfg_bank = 8'd5;
    @(posedge clk);
    #1ns;
    check("R11 no strobe", 2'd0, 7'd77, 1'b0, 8'h88);
    // R7 / R1: reset clears flags and restores slots
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    va_addr = 14'h0400; va_we = 1'b1;
    #1ns;
    check("R7 reset clears", 2'd0, 7'd1, 1'b0, 8'h00);
    @(negedge clk);
    va_addr = 14'h2C00;
    #1ns;
    check("R1 nametable", 2'd2, 7'd3, 1'b1, 8'h00);
    finish_run();
  end
endmodule